// File: doc/BRIEF.md
# Armable Capture/Compare Timer Channel

One channel of a system timer. It time-stamps edges on an input pin that is already synchronised, or it raises an event when a free-running time base reaches a programmed value. Two views of the time base come in from outside: a coarse one and a fine one. A resolution bit picks which view the channel uses. The counter that produces these views, and the logic that gathers interrupts from several channels, are outside this block.

A three-state arm machine controls the channel. The states are unarmed, capture and compare. Software moves it between states in four ways: a configuration write, a write to the value register, and two strobes, one that arms and one that disarms. A separate save/restore write path loads the value register and leaves the state alone. Each capture or compare produces a one-cycle event pulse and sets a sticky output bit. An armed status bit shows whether the channel is waiting for something.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset the channel is unarmed, `val_q` is 0, `cfg_q` is 0, and both `out_bit` and `evt_pulse` are 0.
- R2: The configuration word is laid out as bit0 = mode, bits 2:1 = edge select, bit3 = rearm and bit4 = resolution. It reads back on `cfg_q`. A write with mode 1 puts the channel in capture. A write with mode 0 unarms it, and pin edges are then ignored.
- R3: An edge is a change of `pin_in` between two consecutive clock samples. Edge select 0 captures on a rise, 1 on a fall and 2 on either. Select 3 behaves like 0.
- R4: A capture happens on the clock edge that samples a qualifying pin level. At that edge `val_q` loads the selected time view and `evt_pulse` goes high for exactly the one following cycle.
- R5: When rearm is 1, the channel stays in capture after each capture. When rearm is 0, it returns to unarmed after one capture. Rearm has no effect on a compare.
- R6: Resolution 1 selects `time_fine` for both capture and compare. Resolution 0 selects `time_coarse`.
- R7: A write through `val_we` stores `wr_data` and puts the channel in compare, whatever state it was in before.
- R8: In compare, the channel raises `evt_pulse` for one cycle once the selected view equals `val_q`, and it then becomes unarmed.
- R9: `arm_set` has no effect while the channel is in capture. In any other state it enters compare using the value already held.
- R10: `arm_clr` unarms the channel without an event. The exception is a capture or compare hit in the same cycle: the event is still produced and the channel still ends unarmed.
- R11: A write through `sr_we` loads `val_q` with `wr_data` and leaves both the arm state and `cfg_q` unchanged.
- R12: `armed` is 0 when the channel is unarmed and 1 when it is in capture or compare.
- R13: Every event sets `out_bit`. `out_we` writes `out_wdata` into `out_bit`, but an event in the same cycle takes priority and leaves the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_coarse | input | VAL_W | Coarse time view |
| time_fine | input | VAL_W | Fine time view |
| pin_in | input | 1 | Synchronised input pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word |
| wr_data | input | VAL_W | Data for value and save/restore writes |
| val_we | input | 1 | Value write strobe; arms compare |
| sr_we | input | 1 | Save/restore value write strobe |
| arm_set | input | 1 | Arm-to-compare strobe |
| arm_clr | input | 1 | Disarm strobe |
| out_we | input | 1 | Sticky output write strobe |
| out_wdata | input | 1 | Sticky output write data |
| val_q | output | VAL_W | Capture/compare value |
| cfg_q | output | 5 | Configuration read-back |
| evt_pulse | output | 1 | One-cycle event pulse |
| out_bit | output | 1 | Sticky event output |
| armed | output | 1 | Channel is in capture or compare |

## Verification
The bench builds the channel with `VAL_W = 32` and `RES_SELECTABLE = 1`. With those values both time views and every edge encoding can be selected at run time. The bench drives the two views directly rather than from a counter, so it can place an exact match, or a match on only one view, in any chosen cycle. That control lets it line up an arm-clear, an output write or a save/restore write with a hit in the same cycle.

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel #(
  parameter int VAL_W          = 32,
  parameter bit RES_SELECTABLE = 1'b1,
  parameter bit FIXED_FINE     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] time_coarse,
  input  logic [VAL_W-1:0] time_fine,
  input  logic             pin_in,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_wdata,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             val_we,
  input  logic             sr_we,
  input  logic             arm_set,
  input  logic             arm_clr,
  input  logic             out_we,
  input  logic             out_wdata,
  output logic [VAL_W-1:0] val_q,
  output logic [4:0]       cfg_q,
  output logic             evt_pulse,
  output logic             out_bit,
  output logic             armed
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CAPT = 2'd1, ST_CMP = 2'd2} st_e;

  st_e              state_q, state_d;
  logic [3:0]       cfg_lo_q;
  logic             pin_q;
  logic             fine_sel;
  logic             edge_hit;
  logic             cap_hit, cmp_hit, hit;
  logic [VAL_W-1:0] time_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_lo_q <= '0;
    else if (cfg_we) cfg_lo_q <= cfg_wdata[3:0];

  generate
    if (RES_SELECTABLE) begin : g_res_sel
      logic fine_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      fine_q <= 1'b0;
        else if (cfg_we) fine_q <= cfg_wdata[4];
      assign fine_sel = fine_q;
    end else begin : g_res_fixed
      assign fine_sel = FIXED_FINE;
    end
  endgenerate

  assign cfg_q    = {fine_sel, cfg_lo_q};
  assign time_sel = fine_sel ? time_fine : time_coarse;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_in;

  always_comb begin
    unique case (cfg_lo_q[2:1])
      2'd1:    edge_hit = pin_q & ~pin_in;
      2'd2:    edge_hit = pin_q ^ pin_in;
      default: edge_hit = pin_in & ~pin_q;
    endcase
  end

  assign cap_hit = (state_q == ST_CAPT) && edge_hit;
  assign cmp_hit = (state_q == ST_CMP) && (time_sel == val_q);
  assign hit     = cap_hit | cmp_hit;

  always_comb begin
    state_d = state_q;
    if (cfg_we)
      state_d = cfg_wdata[0] ? ST_CAPT : ST_IDLE;
    else if (val_we)
      state_d = ST_CMP;
    else if (arm_clr)
      state_d = ST_IDLE;
    else if (arm_set && state_q != ST_CAPT)
      state_d = ST_CMP;
    else if (cap_hit)
      state_d = cfg_lo_q[3] ? ST_CAPT : ST_IDLE;
    else if (cmp_hit)
      state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               val_q <= '0;
    else if (val_we || sr_we) val_q <= wr_data;
    else if (cap_hit)         val_q <= time_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_pulse <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      evt_pulse <= hit;
      if (hit)         out_bit <= 1'b1;
      else if (out_we) out_bit <= out_wdata;
    end

  assign armed = (state_q != ST_IDLE);

endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       val_we,
  input logic       sr_we,
  input logic       arm_set,
  input logic       arm_clr,
  input logic       evt_pulse,
  input logic       out_bit,
  input logic       armed,
  input logic [1:0] st
);

  AST_VAL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (val_we && !cfg_we) |=> armed);  // R7

  AST_CMP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !cfg_we && !val_we && !arm_set) |=> (!evt_pulse || !armed));  // R8

  AST_CLR_UNARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_clr && !cfg_we && !val_we) |=> !armed);  // R10

  AST_SR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && !cfg_we && !val_we && !arm_set && !arm_clr) |=> (evt_pulse || $stable(armed)));  // R11

  AST_EVT_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> ($past(st) != 2'd0));  // R12

  AST_EVT_SETS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> out_bit);  // R13

endmodule

bind tmr_cc_channel tmr_cc_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .val_we    (val_we),
  .sr_we     (sr_we),
  .arm_set   (arm_set),
  .arm_clr   (arm_clr),
  .evt_pulse (evt_pulse),
  .out_bit   (out_bit),
  .armed     (armed),
  .st        (state_q)
);

// File: tb/tmr_cc_channel_tb.sv
`timescale 1ns/1ps
module tmr_cc_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] time_coarse = '0, time_fine = '0, wr_data = '0;
  logic        pin_in = 1'b0, cfg_we = 1'b0, val_we = 1'b0, sr_we = 1'b0;
  logic        arm_set = 1'b0, arm_clr = 1'b0, out_we = 1'b0, out_wdata = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [31:0] val_q;
  logic [4:0]  cfg_q;
  logic        evt_pulse, out_bit, armed;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tmr_cc_channel #(.VAL_W(32), .RES_SELECTABLE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .time_coarse(time_coarse), .time_fine(time_fine),
    .pin_in(pin_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .wr_data(wr_data),
    .val_we(val_we), .sr_we(sr_we), .arm_set(arm_set), .arm_clr(arm_clr),
    .out_we(out_we), .out_wdata(out_wdata), .val_q(val_q), .cfg_q(cfg_q),
    .evt_pulse(evt_pulse), .out_bit(out_bit), .armed(armed));

  // {edge select, starting pin level, capture expected}
  localparam logic [3:0] VEC [8] = '{
    4'b00_0_1, 4'b00_1_0, 4'b01_0_0, 4'b01_1_1,
    4'b10_0_1, 4'b10_1_1, 4'b11_0_1, 4'b11_1_0};

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [4:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(); cfg_we = 1'b0;
  endtask
  task automatic val_wr(input logic [31:0] v);
    val_we = 1'b1; wr_data = v; step(); val_we = 1'b0;
  endtask
  task automatic sr_wr(input logic [31:0] v);
    sr_we = 1'b1; wr_data = v; step(); sr_we = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 armed", {31'd0, armed}, 32'd0);
    chk("R1 val", val_q, 32'd0);
    chk("R1 cfg", {27'd0, cfg_q}, 32'd0);
    chk("R1 out", {31'd0, out_bit}, 32'd0);
    chk("R1 evt", {31'd0, evt_pulse}, 32'd0);

    // R3 R4: edge table
    for (int i = 0; i < 8; i++) begin
      logic [3:0] v;
      v = VEC[i];
      pin_in = v[1];
      sr_wr(32'h5555);
      cfg_wr({1'b1, 1'b1, v[3:2], 1'b1});
      time_fine = 32'hA000 + i; time_coarse = 32'h3;
      pin_in = ~v[1];
      step();
      chk($sformatf("R3 edge vec%0d evt", i), {31'd0, evt_pulse}, {31'd0, v[0]});
      chk($sformatf("R4 capture vec%0d val", i), val_q, v[0] ? 32'hA000 + i : 32'h5555);
      if (v[0]) begin
        step();
        chk($sformatf("R4 one cycle vec%0d", i), {31'd0, evt_pulse}, 32'd0);
      end
      cfg_wr(5'b0);
    end

    // R7 R8 compare on fine view
    time_fine = 32'h10; time_coarse = 32'h2000;
    cfg_wr(5'b1_0_00_0);
    chk("R2 cfg readback", {27'd0, cfg_q}, 32'h10);
    val_wr(32'h100);
    chk("R7 armed", {31'd0, armed}, 32'd1);
    chk("R12 armed in compare", {31'd0, armed}, 32'd1);
    time_fine = 32'hFF; step();
    chk("R8 no early hit", {31'd0, evt_pulse}, 32'd0);
    time_fine = 32'h100; step();
    chk("R8 hit evt", {31'd0, evt_pulse}, 32'd1);
    chk("R8 unarmed after", {31'd0, armed}, 32'd0);
    chk("R13 out set", {31'd0, out_bit}, 32'd1);
    step();
    chk("R8 fires once", {31'd0, evt_pulse}, 32'd0);

    // R6 coarse view, R5 rearm ignored in compare
    cfg_wr(5'b0_1_00_0);
    time_fine = 32'h300; time_coarse = 32'h5;
    val_wr(32'h300);
    step();
    chk("R6 fine ignored", {31'd0, evt_pulse}, 32'd0);
    time_coarse = 32'h300; step();
    chk("R6 coarse hit", {31'd0, evt_pulse}, 32'd1);
    chk("R5 rearm no effect in compare", {31'd0, armed}, 32'd0);

    // R9 arm_set
    time_coarse = 32'h0;
    arm_set = 1'b1; step(); arm_set = 1'b0;
    chk("R9 rearm compare", {31'd0, armed}, 32'd1);
    time_coarse = 32'h300; step();
    chk("R9 stored value hit", {31'd0, evt_pulse}, 32'd1);
    pin_in = 1'b0;
    cfg_wr(5'b1_1_00_1);
    time_fine = 32'h777;
    arm_set = 1'b1; step(); arm_set = 1'b0;
    chk("R9 capture kept armed", {31'd0, armed}, 32'd1);
    pin_in = 1'b1; step();
    chk("R9 still capturing evt", {31'd0, evt_pulse}, 32'd1);
    chk("R9 still capturing val", val_q, 32'h777);

    // R10 arm_clr
    time_fine = 32'h0;
    val_wr(32'h40);
    arm_clr = 1'b1; step(); arm_clr = 1'b0;
    chk("R10 unarmed", {31'd0, armed}, 32'd0);
    chk("R10 no event", {31'd0, evt_pulse}, 32'd0);
    time_fine = 32'h40; step();
    chk("R10 later match ignored", {31'd0, evt_pulse}, 32'd0);
    time_fine = 32'h0;
    val_wr(32'h50);
    time_fine = 32'h50; arm_clr = 1'b1; step(); arm_clr = 1'b0;
    chk("R10 same-cycle hit evt", {31'd0, evt_pulse}, 32'd1);
    chk("R10 same-cycle hit unarmed", {31'd0, armed}, 32'd0);

    // R11 save/restore
    time_fine = 32'h0;
    val_wr(32'h60);
    sr_wr(32'h61);
    chk("R11 state kept", {31'd0, armed}, 32'd1);
    chk("R11 val", val_q, 32'h61);
    chk("R11 cfg kept", {27'd0, cfg_q}, 32'h19);
    time_fine = 32'h61; step();
    chk("R11 compare on restored", {31'd0, evt_pulse}, 32'd1);
    sr_wr(32'h62);
    chk("R11 unarmed kept", {31'd0, armed}, 32'd0);

    // R5 single capture
    pin_in = 1'b0;
    cfg_wr(5'b1_0_00_1);
    time_fine = 32'hAAA; pin_in = 1'b1; step();
    chk("R5 one-shot capture", val_q, 32'hAAA);
    chk("R5 one-shot unarmed", {31'd0, armed}, 32'd0);
    pin_in = 1'b0; step();
    time_fine = 32'hBBB; pin_in = 1'b1; step();
    chk("R5 second edge ignored evt", {31'd0, evt_pulse}, 32'd0);
    chk("R5 second edge ignored val", val_q, 32'hAAA);

    // R5 continuous capture, both edges
    cfg_wr(5'b1_1_10_1);
    time_fine = 32'hC01; pin_in = 1'b0; step();
    chk("R5 continuous first", val_q, 32'hC01);
    chk("R5 continuous armed", {31'd0, armed}, 32'd1);
    time_fine = 32'hC02; pin_in = 1'b1; step();
    chk("R5 continuous second", val_q, 32'hC02);

    // R2 disable
    cfg_wr(5'b1_1_10_0);
    chk("R2 disabled unarmed", {31'd0, armed}, 32'd0);
    time_fine = 32'hC03; pin_in = 1'b0; step();
    chk("R2 disabled no evt", {31'd0, evt_pulse}, 32'd0);
    chk("R2 disabled val kept", val_q, 32'hC02);

    // R13 sticky output
    out_we = 1'b1; out_wdata = 1'b0; step();
    chk("R13 write 0", {31'd0, out_bit}, 32'd0);
    out_wdata = 1'b1; step();
    chk("R13 write 1", {31'd0, out_bit}, 32'd1);
    out_wdata = 1'b0; step(); out_we = 1'b0;
    time_fine = 32'h0;
    val_wr(32'h70);
    time_fine = 32'h70; out_we = 1'b1; out_wdata = 1'b0; step(); out_we = 1'b0;
    chk("R13 event beats write", {31'd0, out_bit}, 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule